// File: doc/BRIEF.md
# Interrupt Link Router

This block steers eight shared, level-sensitive interrupt links onto a vector of sixteen legacy IRQ lines. Each link owns a small routing register that holds a disable flag and a four-bit target IRQ number. Software reads and writes these registers through a byte-wide port. The port selects a register by a link number from 1 to 8.

Interrupt sources do not drive the links directly. Each link has a pulse input that marks a source going active and a second pulse input that marks a source going inactive. The block keeps an active-source count for each link. A link raises its target IRQ while its count is nonzero and its routing register is valid. Every output line is the OR of all links that currently drive it. If software rewrites a register while its link is active, the level moves from the old line to the new one on the next clock edge.

Top module: `link_irq_router`

## Requirements
- R1: After reset, every link register reads 0x80, every IRQ line is low and the underflow flag is low.
- R2: A write to link number n (1 to 8) stores register n-1. Only bit 7 (disable) and bits 3:0 (IRQ number) of the written byte are kept. A read returns the stored byte with bits 6:4 as zero.
- R3: A write with link number 0 or 9 to 15 changes no register. A read with such a link number returns 0x00.
- R4: Read data is combinational and appears in the same cycle as the read strobe. While the read strobe is low, the read data is 0x00.
- R5: A link is valid only when bit 7 is clear and its IRQ number is in the permitted set {3,4,5,6,7,9,10,11,12,14,15} (mask 0xDEF8). A link with any other IRQ number never drives an output.
- R6: A link with bit 7 set never drives an output, whatever its IRQ number.
- R7: Each assert pulse adds one to the link's count and each deassert pulse removes one. A valid link drives output bit [IRQ number] from the edge after its count becomes nonzero until the edge that returns the count to zero.
- R8: Assert and deassert pulses on the same link in the same cycle leave its count unchanged.
- R9: A register write that changes the stored value of an active link moves its level from the old IRQ line (if the old value was valid) to the new IRQ line (if the new value is valid) at that clock edge. A write that leaves the stored value unchanged leaves the outputs unchanged.
- R10: When several active valid links target the same IRQ line, that line stays high until the last of them becomes inactive.
- R11: A deassert pulse on a link whose count is zero leaves the count at zero and sets a sticky underflow flag that only reset clears.
- R12: An 8-bit count holds at 255 when more assert pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regLink | input | 4 | Link number 1 to 8 for the access |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational |
| assertEv | input | 8 | One pulse per link: a source went active |
| deassertEv | input | 8 | One pulse per link: a source went inactive |
| irqOut | output | 16 | IRQ line levels |
| underflowErr | output | 1 | Sticky flag: deassert seen at a zero count |

## Verification
Two collisions need their own tests. The first is a register write landing in the same cycle as an assert pulse on that link. The bench drives both on one link in one cycle. It then expects the new target line, and no other line, to be high after the edge. The second is an assert pulse and a deassert pulse hitting the same link together. The bench provokes this with the count at one and at zero. It judges the result by whether the output stays high, and by whether a single later deassert drops the line and leaves the underflow flag clear.

// File: rtl/link_router_pkg.sv
package link_router_pkg;
  localparam int NUM_LINKS   = 8;
  localparam int IRQ_LINES   = 16;
  localparam int IRQ_W       = $clog2(IRQ_LINES);
  localparam int DATA_W      = 8;
  localparam int LINK_ADDR_W = 4;
  localparam int CNT_W       = 8;
  localparam int DIS_BIT     = 7;
  localparam logic [IRQ_LINES-1:0] PERMIT_MASK = 16'hDEF8;
  localparam logic [DATA_W-1:0]    FIELD_MASK  = 8'h8F;
  localparam logic [DATA_W-1:0]    RESET_VAL   = 8'h80;

  typedef struct packed {
    logic [NUM_LINKS-1:0] wrSel;
    logic [NUM_LINKS-1:0] rdSel;
    logic [NUM_LINKS-1:0] incSel;
    logic [NUM_LINKS-1:0] decSel;
  } strobe_t;
endpackage

// File: rtl/link_router_ctrl.sv
module link_router_ctrl
  import link_router_pkg::*;
(
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [LINK_ADDR_W-1:0] regLink,
  input  logic [NUM_LINKS-1:0]   assertEv,
  input  logic [NUM_LINKS-1:0]   deassertEv,
  output strobe_t                strobe,
  output logic                   linkInRange
);
  always_comb begin
    linkInRange = (regLink != '0) && (regLink <= LINK_ADDR_W'(NUM_LINKS));
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_sel
    logic hit;
    assign hit = (regLink == LINK_ADDR_W'(i + 1));
    assign strobe.wrSel[i]  = regWrEn & hit;
    assign strobe.rdSel[i]  = regRdEn & hit;
    assign strobe.incSel[i] = assertEv[i];
    assign strobe.decSel[i] = deassertEv[i];
  end
endmodule

// File: rtl/link_router_dp.sv
module link_router_dp
  import link_router_pkg::*;
#(
  parameter int CntW = CNT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [IRQ_LINES-1:0] irqOut,
  output logic                 underflowErr
);
  localparam logic [CntW-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0]    linkReg [NUM_LINKS];
  logic [CntW-1:0]      count   [NUM_LINKS];
  logic [NUM_LINKS-1:0] linkValid;
  logic [NUM_LINKS-1:0] linkDrive;
  logic [NUM_LINKS-1:0] underHit;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) linkReg[i] <= RESET_VAL;
      else if (strobe.wrSel[i]) linkReg[i] <= wrData & FIELD_MASK;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) count[i] <= '0;
      else begin
        unique case ({strobe.incSel[i], strobe.decSel[i]})
          2'b10:   if (count[i] != CNT_MAX) count[i] <= count[i] + 1'b1;
          2'b01:   if (count[i] != '0)      count[i] <= count[i] - 1'b1;
          default: count[i] <= count[i];
        endcase
      end
    end

    assign underHit[i]  = strobe.decSel[i] & ~strobe.incSel[i] & (count[i] == '0);
    assign linkValid[i] = ~linkReg[i][DIS_BIT] & PERMIT_MASK[linkReg[i][IRQ_W-1:0]];
    assign linkDrive[i] = linkValid[i] & (count[i] != '0);

    assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rstN)
      (count[i] == CNT_MAX && strobe.incSel[i] && !strobe.decSel[i]) |=> (count[i] == CNT_MAX));
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rstN)
      (count[i] == '0 && strobe.decSel[i] && !strobe.incSel[i]) |=> (count[i] == '0 && underflowErr));
    assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.incSel[i] && strobe.decSel[i]) |=> $stable(count[i]));
    assert_field_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
      linkReg[i][6:4] == 3'b000);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) underflowErr <= 1'b0;
    else if (|underHit) underflowErr <= 1'b1;
  end

  always_comb begin
    irqOut = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (linkDrive[i]) irqOut[linkReg[i][IRQ_W-1:0]] = 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (strobe.rdSel[i]) rdData = rdData | linkReg[i];
    end
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);
  assert_permit_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~PERMIT_MASK) == '0);
  assert_needs_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> (|linkDrive));
endmodule

// File: rtl/link_irq_router.sv
module link_irq_router
  import link_router_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [LINK_ADDR_W-1:0] regLink,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  input  logic [NUM_LINKS-1:0]   assertEv,
  input  logic [NUM_LINKS-1:0]   deassertEv,
  output logic [IRQ_LINES-1:0]   irqOut,
  output logic                   underflowErr
);
  strobe_t strobe;
  logic    linkInRange;

  link_router_ctrl u_ctrl (
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regLink     (regLink),
    .assertEv    (assertEv),
    .deassertEv  (deassertEv),
    .strobe      (strobe),
    .linkInRange (linkInRange)
  );

  link_router_dp #(.CntW(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (regWrData),
    .rdData       (regRdData),
    .irqOut       (irqOut),
    .underflowErr (underflowErr)
  );

  assert_bad_link_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !linkInRange) |-> (regRdData == '0));
  assert_idle_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |-> (regRdData == '0));
endmodule

// File: tb/link_irq_router_tb.sv
module link_irq_router_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [3:0]  regLink = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [7:0]  assertEv = '0;
  logic [7:0]  deassertEv = '0;
  logic [15:0] irqOut;
  logic        underflowErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_irq_router u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regLink(regLink), .regWrData(regWrData), .regRdData(regRdData),
    .assertEv(assertEv), .deassertEv(deassertEv), .irqOut(irqOut),
    .underflowErr(underflowErr)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wrReg(int link, logic [7:0] d);
    @(negedge clk);
    regLink = link[3:0]; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(int link, output logic [7:0] d);
    @(negedge clk);
    regLink = link[3:0]; regRdEn = 1'b1;
    #1 d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic pulse(logic [7:0] a, logic [7:0] dd);
    @(negedge clk);
    assertEv = a; deassertEv = dd;
    @(negedge clk);
    assertEv = '0; deassertEv = '0;
  endtask

  function automatic logic [15:0] expOut(logic [7:0] r);
    logic ok;
    ok = !r[7] && ((16'hDEF8 >> r[3:0]) & 16'h1) != 0;
    return ok ? (16'h1 << r[3:0]) : 16'h0;
  endfunction

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int l = 1; l <= 8; l++) begin
      rdReg(l, d); chk("R1 reset reg", d, 8'h80);
    end
    chk("R1 reset irq", irqOut, 0);
    chk("R1 reset err", underflowErr, 0);

    // R3 out of range link numbers
    wrReg(0, 8'h05); wrReg(9, 8'h05); wrReg(15, 8'h05);
    rdReg(0, d); chk("R3 read link0", d, 0);
    rdReg(12, d); chk("R3 read link12", d, 0);
    for (int l = 1; l <= 8; l++) begin
      rdReg(l, d); chk("R3 regs untouched", d, 8'h80);
    end
    // R4 idle read data
    @(negedge clk); regLink = 4'd1; #1 chk("R4 no strobe read", regRdData, 0);

    // R2 R5 R6 R7 sweep of links, IRQ numbers, disable bit
    for (int l = 1; l <= 8; l++) begin
      for (int v = 0; v < 32; v++) begin
        logic [7:0] w;
        w = {v[4], 3'((v * 5 + l) & 7), v[3:0]};
        wrReg(l, w);
        rdReg(l, d); chk("R2 readback", d, w & 8'h8F);
        chk("R7 idle no drive", irqOut, 0);
        pulse(8'h1 << (l - 1), 8'h0);
        chk("R5 R6 R7 drive", irqOut, expOut(w & 8'h8F));
        pulse(8'h0, 8'h1 << (l - 1));
        chk("R7 released", irqOut, 0);
      end
      wrReg(l, 8'h80);
    end

    // R7 multiple sources on one link
    wrReg(1, 8'h05);
    pulse(8'h01, 0); pulse(8'h01, 0); pulse(8'h01, 0);
    pulse(0, 8'h01); pulse(0, 8'h01);
    chk("R7 one source left", irqOut, 16'h0020);
    // R8 simultaneous pulses at count one
    pulse(8'h01, 8'h01);
    chk("R8 pair keeps level", irqOut, 16'h0020);
    pulse(0, 8'h01);
    chk("R7 last release", irqOut, 0);
    // R8 simultaneous pulses at count zero
    pulse(8'h01, 8'h01);
    chk("R8 pair at zero no drive", irqOut, 0);
    chk("R8 pair at zero no error", underflowErr, 0);

    // R9 rewrite while active
    wrReg(2, 8'h07);
    pulse(8'h02, 0);
    chk("R9 start", irqOut, 16'h0080);
    wrReg(2, 8'h0A); chk("R9 move", irqOut, 16'h0400);
    wrReg(2, 8'h8A); chk("R9 disabled", irqOut, 0);
    wrReg(2, 8'h0D); chk("R9 reserved", irqOut, 0);
    wrReg(2, 8'h0B); chk("R9 back valid", irqOut, 16'h0800);
    wrReg(2, 8'h3B); chk("R9 same value", irqOut, 16'h0800);
    rdReg(2, d); chk("R9 same value stored", d, 8'h0B);
    pulse(0, 8'h02);
    chk("R9 released", irqOut, 0);
    // R9 write and assert in the same cycle
    @(negedge clk);
    regLink = 4'd3; regWrData = 8'h04; regWrEn = 1'b1; assertEv = 8'h04;
    @(negedge clk);
    regWrEn = 1'b0; assertEv = 0;
    chk("R9 write with assert", irqOut, 16'h0010);
    pulse(0, 8'h04);

    // R10 shared line
    wrReg(4, 8'h09); wrReg(5, 8'h09);
    pulse(8'h18, 0);
    chk("R10 both", irqOut, 16'h0200);
    pulse(0, 8'h08);
    chk("R10 one left", irqOut, 16'h0200);
    pulse(0, 8'h10);
    chk("R10 none", irqOut, 0);

    // R11 underflow
    wrReg(6, 8'h03);
    chk("R11 err clear before", underflowErr, 0);
    pulse(0, 8'h20);
    chk("R11 err set", underflowErr, 1);
    chk("R11 no drive", irqOut, 0);
    pulse(8'h20, 0);
    chk("R11 count from zero", irqOut, 16'h0008);
    pulse(0, 8'h20);
    chk("R11 released", irqOut, 0);
    chk("R11 err sticky", underflowErr, 1);

    // R12 saturation at 255
    wrReg(7, 8'h0E);
    for (int k = 0; k < 260; k++) pulse(8'h40, 0);
    for (int k = 0; k < 254; k++) pulse(0, 8'h40);
    chk("R12 still one", irqOut, 16'h4000);
    pulse(0, 8'h40);
    chk("R12 saturated count", irqOut, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule